// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the status and error flags of an asynchronous serial receiver. The receiver datapath sends it one-cycle event pulses: a stop bit sampled together with its level, a parity mismatch, a completed character, an all-zero break character, a low level at the first sample of the start-bit search, a false start, and an idle line. From these pulses the block maintains five flags: framing error, parity error, break, receive-data-full and reception-busy. It also drives an error interrupt request and a strobe that clears the received ninth bit.

Software clears a flag in two steps. First it reads the status register that holds the flag while the flag is high, which arms that flag. A later read of the data register then clears every flag that is armed. After a break has been flagged, the break flag can set again only once the line has been seen high. The bus read strobes, the two interrupt enables, the 9-bit mode level and the sampled line level are plain inputs.

Top module: `rx_flag_unit`

## Requirements
- R1: `frm_err` rises on the clock edge after `ev_stop` pulses with `ev_stop_val` at 0. It also sets with a break (R6). A stop event with `ev_stop_val` at 1 leaves it unchanged.
- R2: `par_err` rises on the clock edge after an `ev_par_err` pulse.
- R3: `data_full` rises on the clock edge after an `ev_char_done` pulse.
- R4: A flag clears only in two steps. A read of its status register while the flag is high arms it: `rd_stat1` arms `frm_err`, `par_err` and `data_full`, and `rd_stat2` arms `brk_flag`. A later `rd_data` then clears, on the next edge, exactly the flags that are armed. A `rd_data` with no prior arming changes no flag.
- R5: When a set event for a flag arrives in the same cycle as the `rd_data` that would clear it, the flag stays set and its arming is dropped. A further `rd_data` then leaves it set.
- R6: An accepted `ev_break` sets `brk_flag`, `frm_err` and `data_full` together on the next edge. While `mode9` is 1, `bit9_clr` is high in the same cycle as `ev_break`, and it is 0 otherwise.
- R7: After a break has set `brk_flag`, further `ev_break` pulses do not set `brk_flag` until a cycle with `line_level` at 1 has been seen. Those pulses still set `frm_err` and `data_full`. The block leaves reset ready to accept a break.
- R8: `err_irq` equals (`frm_err` AND `en_frm_irq`) OR (`par_err` AND `en_par_irq`). `brk_flag` and `rx_busy` never raise it.
- R9: `rx_busy` sets on the edge after `ev_start_low` and clears on the edge after `ev_false_start` or `ev_idle`. If a set and a clear arrive in the same cycle, the set wins.
- R10: `stat2` reads bit 1 = `brk_flag`, bit 0 = `rx_busy`, and bits 7..2 = 0. An asynchronous reset (`rst_n` low) clears every flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_stop | input | 1 | Stop bit sampled (pulse) |
| ev_stop_val | input | 1 | Level of the sampled stop bit |
| ev_par_err | input | 1 | Parity mismatch (pulse) |
| ev_char_done | input | 1 | Character complete (pulse) |
| ev_break | input | 1 | All-zero break character (pulse) |
| ev_start_low | input | 1 | Low at first start-search sample (pulse) |
| ev_false_start | input | 1 | False start detected (pulse) |
| ev_idle | input | 1 | Idle line detected (pulse) |
| line_level | input | 1 | Current sampled receive line level |
| mode9 | input | 1 | 9-bit character mode |
| rd_stat1 | input | 1 | Read strobe, status register 1 |
| rd_stat2 | input | 1 | Read strobe, status register 2 |
| rd_data | input | 1 | Read strobe, data register |
| en_frm_irq | input | 1 | Framing error interrupt enable |
| en_par_irq | input | 1 | Parity error interrupt enable |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| brk_flag | output | 1 | Break flag |
| data_full | output | 1 | Receive data full flag |
| rx_busy | output | 1 | Reception in progress flag |
| stat2 | output | 8 | Packed status register 2 |
| err_irq | output | 1 | Error interrupt request |
| bit9_clr | output | 1 | Clear strobe for the ninth received bit |

## Verification
On every cycle, the assertions check the following: each set event shows up in its flag one edge later; a flag can fall only after a data read; an accepted break raises three flags together; the busy flag follows its set-wins rule; and the break flag alone never requests an interrupt. Some behaviour depends on a history of several reads and line levels, and only the bench's sequences can show it. This covers an unarmed data read having no effect, arming being lost to a same-cycle set, a second break being ignored until the line goes high, and one data read clearing exactly the armed subset of flags.

// File: rtl/rx_flag_unit.sv
module rx_flag_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_stop,
  input  logic       ev_stop_val,
  input  logic       ev_par_err,
  input  logic       ev_char_done,
  input  logic       ev_break,
  input  logic       ev_start_low,
  input  logic       ev_false_start,
  input  logic       ev_idle,
  input  logic       line_level,
  input  logic       mode9,
  input  logic       rd_stat1,
  input  logic       rd_stat2,
  input  logic       rd_data,
  input  logic       en_frm_irq,
  input  logic       en_par_irq,
  output logic       frm_err,
  output logic       par_err,
  output logic       brk_flag,
  output logic       data_full,
  output logic       rx_busy,
  output logic [7:0] stat2,
  output logic       err_irq,
  output logic       bit9_clr
);

  localparam int NF = 4;
  localparam int FE = 0, PE = 1, BK = 2, DF = 3;

  logic [NF-1:0] flag_q, armed_q, set_v, arm_rd;
  logic          brk_rearm_q;

  assign set_v[FE] = (ev_stop & ~ev_stop_val) | ev_break;
  assign set_v[PE] = ev_par_err;
  assign set_v[BK] = ev_break & brk_rearm_q;
  assign set_v[DF] = ev_char_done | ev_break;

  assign arm_rd[FE] = rd_stat1;
  assign arm_rd[PE] = rd_stat1;
  assign arm_rd[BK] = rd_stat2;
  assign arm_rd[DF] = rd_stat1;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i]  <= 1'b0;
        armed_q[i] <= 1'b0;
      end else if (set_v[i]) begin
        flag_q[i]  <= 1'b1;
        armed_q[i] <= 1'b0;
      end else if (rd_data && armed_q[i]) begin
        flag_q[i]  <= 1'b0;
        armed_q[i] <= 1'b0;
      end else if (arm_rd[i] && flag_q[i]) begin
        armed_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              brk_rearm_q <= 1'b1;
    else if (set_v[BK])      brk_rearm_q <= 1'b0;
    else if (line_level)     brk_rearm_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rx_busy <= 1'b0;
    else if (ev_start_low) rx_busy <= 1'b1;
    else if (ev_false_start || ev_idle) rx_busy <= 1'b0;
  end

  assign frm_err   = flag_q[FE];
  assign par_err   = flag_q[PE];
  assign brk_flag  = flag_q[BK];
  assign data_full = flag_q[DF];
  assign stat2     = {6'b0, brk_flag, rx_busy};
  assign err_irq   = (frm_err & en_frm_irq) | (par_err & en_par_irq);
  assign bit9_clr  = ev_break & mode9;

  assert_fe_on_bad_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_stop_val) |=> frm_err);

  assert_pe_on_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par_err |=> par_err);

  assert_full_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_char_done |=> data_full);

  assert_fe_falls_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_err) |-> $past(rd_data));

  assert_brk_falls_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_flag) |-> $past(rd_data));

  assert_break_triple_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_break && brk_rearm_q) |=> (brk_flag && frm_err && data_full));

  assert_brk_rises_on_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(ev_break));

  assert_brk_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_err && !par_err) |-> !err_irq);

  assert_busy_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_low |=> rx_busy);

  assert_busy_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_false_start || ev_idle) && !ev_start_low) |=> !rx_busy);

endmodule

// File: tb/rx_flag_unit_bench.sv
module rx_flag_unit_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_stop = 0, ev_stop_val = 0, ev_par_err = 0, ev_char_done = 0, ev_break = 0;
  logic ev_start_low = 0, ev_false_start = 0, ev_idle = 0, line_level = 0, mode9 = 0;
  logic rd_stat1 = 0, rd_stat2 = 0, rd_data = 0, en_frm_irq = 0, en_par_irq = 0;
  logic frm_err, par_err, brk_flag, data_full, rx_busy, err_irq, bit9_clr;
  logic [7:0] stat2;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rx_flag_unit u_rx_flag_unit (
    .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_stop_val(ev_stop_val),
    .ev_par_err(ev_par_err), .ev_char_done(ev_char_done), .ev_break(ev_break),
    .ev_start_low(ev_start_low), .ev_false_start(ev_false_start), .ev_idle(ev_idle),
    .line_level(line_level), .mode9(mode9), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
    .rd_data(rd_data), .en_frm_irq(en_frm_irq), .en_par_irq(en_par_irq),
    .frm_err(frm_err), .par_err(par_err), .brk_flag(brk_flag), .data_full(data_full),
    .rx_busy(rx_busy), .stat2(stat2), .err_irq(err_irq), .bit9_clr(bit9_clr)
  );

  // inputs: stop,stop_val,par,done | brk,start_low,false_st,idle | line,rd1,rd2,rdd
  // expected: fe,pe,brk,full,busy
  localparam int NROW = 28;
  localparam logic [16:0] TBL [NROW] = '{
    {12'b1000_0000_0000, 5'b10000},  // R1
    {12'b0000_0000_0001, 5'b10000},  // R4 unarmed read
    {12'b0000_0000_0100, 5'b10000},  // R4 arm
    {12'b0000_0000_0001, 5'b00000},  // R4 clear
    {12'b0010_0000_0000, 5'b01000},  // R2
    {12'b0001_0000_0000, 5'b01010},  // R3
    {12'b0000_0000_0100, 5'b01010},  // R4 arm pe, full
    {12'b0010_0000_0001, 5'b01000},  // R5 set wins
    {12'b0000_0000_0001, 5'b01000},  // R5 arming dropped
    {12'b0000_0000_0100, 5'b01000},  // R4
    {12'b0000_0000_0001, 5'b00000},  // R4
    {12'b0000_0100_0000, 5'b00001},  // R9
    {12'b0000_0001_0000, 5'b00000},  // R9 idle
    {12'b0000_0100_0000, 5'b00001},  // R9
    {12'b0000_0010_0000, 5'b00000},  // R9 false start
    {12'b0000_0101_0000, 5'b00001},  // R9 tie
    {12'b0000_0001_0000, 5'b00000},  // R9
    {12'b0000_1000_0000, 5'b10110},  // R6
    {12'b0000_0000_0110, 5'b10110},  // R4 arm both regs
    {12'b0000_0000_0001, 5'b00000},  // R4
    {12'b0000_1000_0000, 5'b10010},  // R7 not rearmed
    {12'b0000_0000_0100, 5'b10010},  // R7
    {12'b0000_0000_0001, 5'b00000},  // R7
    {12'b0000_0000_1000, 5'b00000},  // R7 line high
    {12'b0000_1000_0000, 5'b10110},  // R7 rearmed
    {12'b1100_0000_0000, 5'b10110},  // R1 good stop
    {12'b0000_0000_0010, 5'b10110},  // R4 arm brk only
    {12'b0000_0000_0001, 5'b10010}   // R4 subset cleared
  };

  function automatic string row_tag(int r);
    case (r)
      0, 25: return "R1";
      4: return "R2";
      5: return "R3";
      7, 8: return "R5";
      11, 12, 13, 14, 15, 16: return "R9";
      17: return "R6";
      20, 21, 22, 23, 24: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [11:0] v);
    @(negedge clk);
    {ev_stop, ev_stop_val, ev_par_err, ev_char_done, ev_break, ev_start_low,
     ev_false_start, ev_idle, line_level, rd_stat1, rd_stat2, rd_data} = v;
    #1;
  endtask

  task automatic release_inputs();
    @(negedge clk);
    {ev_stop, ev_stop_val, ev_par_err, ev_char_done, ev_break, ev_start_low,
     ev_false_start, ev_idle, line_level, rd_stat1, rd_stat2, rd_data} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] flags();
    return {3'b0, frm_err, par_err, brk_flag, data_full, rx_busy};
  endfunction

  initial begin
    do_reset();
    check("R10 reset flags", flags(), 8'h00);
    check("R10 reset stat2", stat2, 8'h00);
    check("R8 reset irq", {7'b0, err_irq}, 8'h00);

    for (int r = 0; r < NROW; r++) begin
      apply(TBL[r][16:5]);
      release_inputs();
      check(row_tag(r), flags(), {3'b0, TBL[r][4:0]});
    end

    do_reset();
    check("R10 reset after activity", flags(), 8'h00);
    mode9 = 1'b1;
    apply(12'b0000_1000_0000);
    check("R6 bit9_clr in 9-bit mode", {7'b0, bit9_clr}, 8'h01);
    release_inputs();
    check("R7 break accepted from reset", flags(), 8'h16);
    apply(12'b0000_0000_0100);
    release_inputs();
    apply(12'b0000_0000_0001);
    release_inputs();
    check("R4 only brk left", flags(), 8'h04);
    en_frm_irq = 1'b1;
    en_par_irq = 1'b1;
    #1;
    check("R8 break raises no irq", {7'b0, err_irq}, 8'h00);
    check("R10 stat2 break bit", stat2, 8'h02);
    apply(12'b0000_0100_0000);
    release_inputs();
    check("R10 stat2 both bits", stat2, 8'h03);

    mode9 = 1'b0;
    en_frm_irq = 1'b0;
    apply(12'b1000_1000_0000);
    check("R6 bit9_clr off in 8-bit mode", {7'b0, bit9_clr}, 8'h00);
    release_inputs();
    check("R8 fe gated by enable", {7'b0, err_irq}, 8'h00);
    en_frm_irq = 1'b1;
    #1;
    check("R8 fe enabled", {7'b0, err_irq}, 8'h01);

    do_reset();
    en_frm_irq = 1'b0;
    en_par_irq = 1'b1;
    apply(12'b0010_0000_0000);
    release_inputs();
    check("R8 pe enabled", {7'b0, err_irq}, 8'h01);
    en_par_irq = 1'b0;
    #1;
    check("R8 pe gated", {7'b0, err_irq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule